// File: doc/BRIEF.md
# Integer and Floating-Point Word Converter

This block converts between N-bit two's-complement integers and a 32-bit floating-point word. It handles one conversion at a time, and the `toFloat` input picks the direction for that conversion. The float word holds a sign in bit 31 and an 8-bit exponent in bits 30:23. The exponent is biased by 128, so a stored value e stands for 2^(e-128). The remaining 23 bits hold a fraction. The significand has a leading one that is not stored. An integer is taken as a whole number with its binary point to the right of bit 0.

In the integer-to-float direction, the magnitude of the integer is normalized. The block finds the leading one and shifts the magnitude left so that the bits below the leading one fill the fraction from the top. In the float-to-integer direction, the exponent has the bias removed. The significand is shifted right, which drops every fractional bit, and the result is negated when the sign bit is set. A float whose magnitude is below one therefore gives zero. A float that is too large for N signed bits saturates to the nearest N-bit limit.

A caller raises `start` for one cycle with its operands while `busy` is low. The result registers then change and `done` pulses. Each result stays on its output until the next conversion in the same direction. N must lie between 2 and 23, and its default is 16.

Top module: `int_float_conv`

## Requirements
- R1: For a nonzero integer whose magnitude has its highest set bit at position p, the float word is {sign, 128+p, the p bits below that leading one placed left-aligned in bits 22:0 with zeros beneath}. The sign is in bit 31, the exponent in bits 30:23 and the fraction in bits 22:0.
- R2: A negative integer sets bit 31 and is normalized from its two's-complement magnitude. The most negative value -2^(N-1) gives exponent 128+N-1 and an all-zero fraction.
- R3: Integer zero converts to the all-zero float word 32'h00000000.
- R4: For a float with exponent e where 128 <= e < 128+N-1, the integer result is floor(1.fraction x 2^(e-128)). This value is negated when bit 31 is 1.
- R5: A float with exponent below 128, including an all-zero exponent, converts to integer zero whatever its sign and fraction.
- R6: A float with exponent at or above 128+N-1 saturates. The result is 2^(N-1)-1 when bit 31 is 0 and -2^(N-1) when bit 31 is 1.
- R7: `start` is accepted only while `busy` is low. `busy` is high in the cycle after acceptance. `done` is high for exactly one cycle, two clock edges after the edge that accepted `start`.
- R8: A `start` raised while `busy` is high is ignored. The outputs carry the result of the conversion that was accepted, and no extra `done` follows.
- R9: After reset both outputs are zero. A conversion updates only the output for its own direction, and every output holds its value between updates.
- R10: `start` may be raised in the same cycle that `done` is high. That conversion is accepted, and it finishes after the same two edges as a conversion started from rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a conversion; sampled while idle |
| toFloat | input | 1 | 1: integer to float, 0: float to integer |
| intIn | input | N | Two's-complement integer operand |
| floatIn | input | 32 | Floating-point operand |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when a result is registered |
| floatOut | output | 32 | Float result of the last integer-to-float conversion |
| intOut | output | N | Integer result of the last float-to-integer conversion |

## Verification
A new request can arrive in the same cycle that the previous conversion raises `done`, because the controller is idle again by then. The bench provokes this by raising `start` with an operand for the other direction exactly in the `done` cycle. It then checks three things: `busy` rises at the next edge, a second `done` comes two edges after acceptance, and each output holds the result for its own direction. A request raised during the busy cycle is checked in the same way. The result must still belong to the first operand, and no second pulse may follow.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  localparam int FLT_W  = 32;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int BIAS   = 128;

  typedef struct packed {
    logic load;
    logic commit;
  } cvtStrobe_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } cvtState_t;
endpackage

// File: rtl/cvt_lead_one.sv
module cvt_lead_one #(
  parameter int W  = 16,
  parameter int PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [PW-1:0] pos,
  output logic          any
);
  always_comb begin
    pos = '0;
    any = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        pos = PW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cvt_ctrl.sv
module cvt_ctrl
  import cvt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output cvtStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  cvtState_t state, nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_CONV: begin
        strobe.commit = 1'b1;
        nextState     = ST_IDLE;
      end
      default: begin
        if (start) begin
          strobe.load = 1'b1;
          nextState   = ST_CONV;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= strobe.commit;
    end
  end

  assign busy = (state == ST_CONV);

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |-> ##2 done); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> !busy); // R8
endmodule

// File: rtl/cvt_datapath.sv
module cvt_datapath
  import cvt_pkg::*;
#(
  parameter int N = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cvtStrobe_t       strobe,
  input  logic             toFloat,
  input  logic [N-1:0]     intIn,
  input  logic [FLT_W-1:0] floatIn,
  output logic [FLT_W-1:0] floatOut,
  output logic [N-1:0]     intOut
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;
  localparam logic [EXP_W-1:0] SAT_EXP = EXP_W'(BIAS + N - 1);
  localparam logic [N-1:0] INT_MAX = {1'b0, {(N-1){1'b1}}};
  localparam logic [N-1:0] INT_MIN = {1'b1, {(N-1){1'b0}}};

  logic             opDir;
  logic [N-1:0]     opInt;
  logic [FLT_W-1:0] opFloat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opDir   <= 1'b0;
      opInt   <= '0;
      opFloat <= '0;
    end else if (strobe.load) begin
      opDir   <= toFloat;
      opInt   <= intIn;
      opFloat <= floatIn;
    end
  end

  // integer to float
  logic              intSign;
  logic [N-1:0]      intMag;
  logic [PW-1:0]     leadPos;
  logic              leadAny;
  logic [FRAC_W:0]   magWide;
  logic [FRAC_W-1:0] fwdFrac;
  logic [EXP_W-1:0]  fwdExp;
  logic [FLT_W-1:0]  fwdWord;

  assign intSign = opInt[N-1];
  assign intMag  = intSign ? -opInt : opInt;

  cvt_lead_one #(.W(N), .PW(PW)) uLead (
    .vec(intMag),
    .pos(leadPos),
    .any(leadAny)
  );

  always_comb begin
    magWide = (FRAC_W+1)'(intMag);
    fwdFrac = FRAC_W'(magWide << (5'd23 - 5'(leadPos)));
    fwdExp  = EXP_W'(BIAS) + EXP_W'(leadPos);
    fwdWord = leadAny ? {intSign, fwdExp, fwdFrac} : '0;
  end

  // float to integer
  logic              fltSign;
  logic [EXP_W-1:0]  fltExp;
  logic [FRAC_W-1:0] fltFrac;
  logic [EXP_W-1:0]  unbExp;
  logic [N-1:0]      revMag;
  logic [N-1:0]      revWord;

  assign fltSign = opFloat[FLT_W-1];
  assign fltExp  = opFloat[FLT_W-2:FRAC_W];
  assign fltFrac = opFloat[FRAC_W-1:0];
  assign unbExp  = fltExp - EXP_W'(BIAS);

  always_comb begin
    revMag = N'({1'b1, fltFrac} >> 5'(8'd23 - unbExp));
    if (fltExp < EXP_W'(BIAS)) begin
      revWord = '0;
    end else if (fltExp >= SAT_EXP) begin
      revWord = fltSign ? INT_MIN : INT_MAX;
    end else begin
      revWord = fltSign ? -revMag : revMag;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      floatOut <= '0;
      intOut   <= '0;
    end else if (strobe.commit) begin
      if (opDir) floatOut <= fwdWord;
      else       intOut   <= revWord;
    end
  end

  AST_ZERO_INT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && opDir && opInt == '0) |=> floatOut == '0); // R3
  AST_EXP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && opDir && opInt != '0) |=>
      (floatOut[30:23] >= 8'd128) && (floatOut[30:23] <= SAT_EXP)); // R1
  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && opDir) |=> floatOut[31] == $past(opInt[N-1])); // R2
  AST_BELOW_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && !opDir && opFloat[30:23] < 8'd128) |=> intOut == '0); // R5
  AST_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && !opDir && opFloat[30:23] >= SAT_EXP) |=>
      intOut == (opFloat[31] ? INT_MIN : INT_MAX)); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(floatOut) && $stable(intOut)); // R9
  AST_HOLD_OTHER: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && opDir) |=> $stable(intOut)); // R9
endmodule

// File: rtl/int_float_conv.sv
module int_float_conv
  import cvt_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         toFloat,
  input  logic [N-1:0] intIn,
  input  logic [31:0]  floatIn,
  output logic         busy,
  output logic         done,
  output logic [31:0]  floatOut,
  output logic [N-1:0] intOut
);
  cvtStrobe_t strobe;

  cvt_ctrl uCtrl (
    .clk(clk),
    .rstN(rstN),
    .start(start),
    .strobe(strobe),
    .busy(busy),
    .done(done)
  );

  cvt_datapath #(.N(N)) uPath (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .toFloat(toFloat),
    .intIn(intIn),
    .floatIn(floatIn),
    .floatOut(floatOut),
    .intOut(intOut)
  );
endmodule

// File: tb/int_float_conv_test.sv
module int_float_conv_test;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         toFloat = 1'b0;
  logic [N-1:0] intIn = '0;
  logic [31:0]  floatIn = '0;
  logic         busy, done;
  logic [31:0]  floatOut;
  logic [N-1:0] intOut;

  int checks = 0;
  int errors = 0;

  int_float_conv #(.N(N)) uut (
    .clk(clk), .rstN(rstN), .start(start), .toFloat(toFloat),
    .intIn(intIn), .floatIn(floatIn), .busy(busy), .done(done),
    .floatOut(floatOut), .intOut(intOut)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] modelFwd(input int v);
    int s, m, p;
    longint fr;
    if (v == 0) return 32'h0;
    s = (v < 0) ? 1 : 0;
    m = (v < 0) ? -v : v;
    p = 0;
    for (int b = 0; b < 31; b++) if (((m >> b) & 1) == 1) p = b;
    fr = longint'(m - (1 << p)) << (23 - p);
    return {s[0], 8'(128 + p), 23'(fr)};
  endfunction

  function automatic logic [N-1:0] modelRev(input logic [31:0] f);
    int e, k;
    longint m;
    e = int'(f[30:23]);
    if (e < 128) return '0;
    k = e - 128;
    if (k >= N - 1) return f[31] ? N'(-(longint'(1) << (N - 1))) : N'((longint'(1) << (N - 1)) - 1);
    m = (longint'(1 << 23) + longint'(f[22:0])) >> (23 - k);
    return f[31] ? N'(-m) : N'(m);
  endfunction

  task automatic runOp(input logic dirF, input logic [N-1:0] iv, input logic [31:0] fv);
    @(negedge clk);
    start = 1'b1; toFloat = dirF; intIn = iv; floatIn = fv;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7 busy after accept", longint'(busy), 1);
    @(negedge clk);
    check(done == 1'b1, "R7 done two edges after accept", longint'(done), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lastF;
    logic [N-1:0] lastI;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(floatOut == 32'h0, "R9 reset floatOut", longint'(floatOut), 0);
    check(intOut == '0, "R9 reset intOut", longint'(intOut), 0);
    check(!busy && !done, "R7 reset idle", longint'({busy, done}), 0);

    // reverse op to seed intOut: 5.5 -> 5
    runOp(1'b0, '0, {1'b0, 8'd130, 23'h300000});
    check(intOut == modelRev({1'b0, 8'd130, 23'h300000}), "R4 seed", longint'(intOut), 5);
    lastI = intOut;

    // exhaustive integer to float sweep (R1, R2, R3)
    for (int v = -(1 << (N - 1)); v < (1 << (N - 1)); v++) begin
      runOp(1'b1, v[N-1:0], 32'h0);
      check(floatOut == modelFwd(v), (v == 0) ? "R3 zero" : ((v < 0) ? "R2 negative" : "R1 forward"),
            longint'(floatOut), longint'(modelFwd(v)));
      check(intOut == lastI, "R9 intOut held", longint'(intOut), longint'(lastI));
    end
    check(modelFwd(-(1 << (N - 1))) == {1'b1, 8'(128 + N - 1), 23'h0}, "R2 model most negative",
          longint'(modelFwd(-(1 << (N - 1)))), 0);
    lastF = floatOut;

    // float to integer sweep over every exponent (R4, R5, R6)
    for (int e = 0; e < 256; e++) begin
      for (int s = 0; s < 2; s++) begin
        for (int fi = 0; fi < 4; fi++) begin
          logic [22:0] fr;
          logic [31:0] w;
          fr = (fi == 0) ? 23'h0 : (fi == 1) ? 23'h7FFFFF : (fi == 2) ? 23'h400000 : 23'h2AAAAA;
          w = {s[0], e[7:0], fr};
          runOp(1'b0, '0, w);
          check(intOut == modelRev(w), (e < 128) ? "R5 below one" : ((e >= 128 + N - 1) ? "R6 saturate" : "R4 reverse"),
                longint'(intOut), longint'(modelRev(w)));
          check(floatOut == lastF, "R9 floatOut held", longint'(floatOut), longint'(lastF));
        end
      end
    end

    // R8: start while busy is ignored
    @(negedge clk);
    start = 1'b1; toFloat = 1'b1; intIn = N'(5);
    @(negedge clk);
    intIn = N'(7);
    check(busy == 1'b1, "R8 busy", longint'(busy), 1);
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R8 done", longint'(done), 1);
    check(floatOut == modelFwd(5), "R8 first operand kept", longint'(floatOut), longint'(modelFwd(5)));
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R8 no second conversion", longint'({done, busy}), 0);

    // R10: start in the done cycle
    runOp(1'b0, '0, {1'b1, 8'd131, 23'h200000});
    lastI = intOut;
    check(intOut == N'(-10), "R4 negative reverse", longint'(intOut), longint'(N'(-10)));
    start = 1'b1; toFloat = 1'b1; intIn = N'(-3);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10 accepted in done cycle", longint'(busy), 1);
    check(done == 1'b0, "R7 done single cycle", longint'(done), 0);
    @(negedge clk);
    check(done == 1'b1, "R10 second done", longint'(done), 1);
    check(floatOut == modelFwd(-3), "R10 back-to-back result", longint'(floatOut), longint'(modelFwd(-3)));
    check(intOut == lastI, "R10 other output held", longint'(intOut), longint'(lastI));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule